// File: doc/BRIEF.md
# Serial DAC Control Front End

This block is the digital side of a single-channel 16-bit voltage DAC that is programmed over a three-wire serial link. The link consists of an active-low frame select, a serial clock and a serial data line. All three are asynchronous to the system clock. They pass through a two-flop synchronizer, and their edges are found in the system clock domain. Data is shifted in on each falling serial-clock edge, most significant bit first. A frame of 24 bits takes effect on the 24th falling edge.

A committed frame either loads a new 16-bit code or moves the output into one of three power-down terminations. In power-down, the stored code is kept. A frame made entirely of ones returns the block to its power-on state. The power-on code is either midscale or zero, chosen at build time. The outputs are the stored code, the two-bit mode, a one-hot termination select for the analog output stage, and a single-cycle strobe that marks each committed frame.

Top module: `serial_dac_frontend`

## Requirements
- R1: While and after reset, with no frame received, `dac_code` holds the power-on code (0x8000 when `RESET_MID`=1, 0x0000 when 0), `op_mode` is 00 and `term_sel` is 4'b0001.
- R2: A frame starts on a falling edge of `sel_n`. Bits are taken MSB first (frame bit 23 first) on falling `sclk` edges. A committed frame whose bits 17:16 are 00 loads frame bits 15:0 into `dac_code`.
- R3: Outputs do not change before the 24th falling `sclk` edge of a frame. Each committed frame raises `upd_stb` high for exactly one system clock cycle. `dac_code` and `op_mode` change only in that cycle.
- R4: If `sel_n` rises before the 24th falling edge, the partial frame is dropped. No output changes and no strobe is produced.
- R5: After a commit, further `sclk` edges while `sel_n` stays low are ignored. A new frame needs `sel_n` to rise and then fall again.
- R6: Frame bits 17:16 set `op_mode`. The codes are 00 drive, 01 three-state, 10 weak pulldown and 11 strong pulldown. `term_sel` is one-hot: bit 0 drive, bit 1 three-state, bit 2 weak pulldown, bit 3 strong pulldown.
- R7: A committed frame with a nonzero mode field leaves `dac_code` unchanged, so the stored code is still present on return to drive.
- R8: Frame bits 23:18 have no effect on a frame that is not the reset word.
- R9: A frame of 24 ones (0xFFFFFF) sets `dac_code` to the power-on code and `op_mode` to 00, and still produces one strobe.
- R10: A frame that is all ones except bit 23 (0x7FFFFF) is treated as an ordinary frame. It selects strong pulldown (mode 11) and keeps the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| sel_n | input | 1 | Serial frame select, active low, asynchronous |
| sclk | input | 1 | Serial clock, data taken on its falling edge, asynchronous |
| sdin | input | 1 | Serial data, MSB first, asynchronous |
| dac_code | output | 16 | Stored converter code |
| op_mode | output | 2 | Operating mode field |
| term_sel | output | 4 | One-hot output termination select |
| upd_stb | output | 1 | One-cycle pulse per committed frame |

## Verification
The properties assume that the serial inputs change slowly compared with the system clock. Each level of `sclk` and `sel_n` must last several system cycles, so that every edge is seen once after synchronization. `sdin` must be settled before the `sclk` fall that samples it, and a frame-select fall and a clock fall must never land in the same synchronized cycle. The stimulus meets these conditions. It holds each serial-clock phase for eight system cycles and changes data only while `sclk` is high. It also waits eight cycles between a frame-select edge and the first or last clock edge. Because a committed frame takes hundreds of cycles, the one-cycle width of the strobe can be checked directly.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_HIZ    = 2'b01,
    MODE_WEAK   = 2'b10,
    MODE_STRONG = 2'b11
  } sdac_mode_e;

  // One-hot termination: bit index equals the mode code
  function automatic logic [3:0] sdac_term_onehot(input logic [1:0] m);
    return 4'b0001 << m;
  endfunction

  function automatic logic sdac_is_powerdown(input logic [1:0] m);
    return m != MODE_RUN;
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_lvl,
  output logic [WIDTH-1:0] q_fall
);
  logic [WIDTH-1:0] stg [STAGES];
  logic [WIDTH-1:0] q_prev;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d_async;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_prev <= RST_VAL;
    else        q_prev <= stg[STAGES-1];
  end

  assign q_lvl  = stg[STAGES-1];
  assign q_fall = q_prev & ~stg[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int FRAME_BITS = 24,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_lvl,
  input  logic                  sel_fall,
  input  logic                  sclk_fall,
  input  logic                  din_lvl,
  output logic                  frame_done,
  output logic [FRAME_BITS-1:0] frame_word,
  output logic [CNT_W-1:0]      bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      bit_cnt    <= '0;
      frame_word <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (sel_lvl) begin
        armed   <= 1'b0;
        bit_cnt <= '0;
      end else if (sel_fall) begin
        armed   <= 1'b1;
        bit_cnt <= '0;
      end else if (armed && sclk_fall) begin
        frame_word <= {frame_word[FRAME_BITS-2:0], din_lvl};
        if (bit_cnt == LAST) begin
          frame_done <= 1'b1;
          armed      <= 1'b0;
          bit_cnt    <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int FRAME_BITS = 24,
  parameter int CODE_W     = 16,
  parameter bit RESET_MID  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_done,
  input  logic [FRAME_BITS-1:0] frame_word,
  output logic [CODE_W-1:0]     dac_code,
  output logic [1:0]            op_mode,
  output logic                  upd_stb
);
  localparam logic [CODE_W-1:0] POR_CODE =
    RESET_MID ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
  localparam int MODE_LSB = CODE_W;

  logic       is_reset;
  logic [1:0] new_mode;

  assign is_reset = &frame_word;
  assign new_mode = frame_word[MODE_LSB+1:MODE_LSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code <= POR_CODE;
      op_mode  <= MODE_RUN;
      upd_stb  <= 1'b0;
    end else begin
      upd_stb <= frame_done;
      if (frame_done) begin
        if (is_reset) begin
          dac_code <= POR_CODE;
          op_mode  <= MODE_RUN;
        end else begin
          op_mode <= new_mode;
          if (!sdac_is_powerdown(new_mode))
            dac_code <= frame_word[CODE_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend
  import sdac_pkg::*;
#(
  parameter int FRAME_BITS  = 24,
  parameter int CODE_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit RESET_MID   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic [CODE_W-1:0] dac_code,
  output logic [1:0]        op_mode,
  output logic [3:0]        term_sel,
  output logic              upd_stb
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [2:0]            s_lvl, s_fall;
  logic                  frame_done;
  logic [FRAME_BITS-1:0] frame_word;
  logic [CNT_W-1:0]      bit_cnt;

  // index 2: select, 1: serial clock, 0: data
  sdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async({sel_n, sclk, sdin}),
    .q_lvl(s_lvl), .q_fall(s_fall)
  );

  sdac_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_lvl(s_lvl[2]), .sel_fall(s_fall[2]),
    .sclk_fall(s_fall[1]), .din_lvl(s_lvl[0]),
    .frame_done(frame_done), .frame_word(frame_word), .bit_cnt(bit_cnt)
  );

  sdac_regs #(.FRAME_BITS(FRAME_BITS), .CODE_W(CODE_W), .RESET_MID(RESET_MID)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .frame_done(frame_done), .frame_word(frame_word),
    .dac_code(dac_code), .op_mode(op_mode), .upd_stb(upd_stb)
  );

  assign term_sel = sdac_term_onehot(op_mode);
endmodule

// File: rtl/sdac_checker.sv
module sdac_checker #(
  parameter int FRAME_BITS = 24,
  parameter int CODE_W     = 16,
  parameter int CNT_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_stb,
  input logic              frame_done,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [CODE_W-1:0] dac_code,
  input logic [1:0]        op_mode,
  input logic [3:0]        term_sel
);
  // R3
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> ($stable(dac_code) && $stable(op_mode)));

  // R2
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> upd_stb);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(bit_cnt) < FRAME_BITS);

  // R7
  pd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && op_mode != 2'b00) |-> dac_code == $past(dac_code));

  // R6
  term_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(term_sel) == 1);
endmodule

bind serial_dac_frontend sdac_checker #(
  .FRAME_BITS(FRAME_BITS), .CODE_W(CODE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .frame_done(frame_done),
  .bit_cnt(bit_cnt), .dac_code(dac_code), .op_mode(op_mode), .term_sel(term_sel)
);

// File: tb/tb_serial_dac_frontend.sv
module tb_serial_dac_frontend;
  localparam int HALF = 8;
  localparam int NV   = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b1, sdin = 1'b1;
  logic [15:0] dac_code;
  logic [1:0]  op_mode;
  logic [3:0]  term_sel;
  logic        upd_stb;

  int total = 0, bad = 0, pulses = 0, cyc = 0;
  logic [15:0] exp_code;
  logic [1:0]  exp_mode;
  int exp_pulses;
  bit done = 1'b0;

  serial_dac_frontend dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
    .dac_code(dac_code), .op_mode(op_mode), .term_sel(term_sel), .upd_stb(upd_stb)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) if (rst_n && upd_stb) pulses++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // word, expected code, expected mode
  localparam logic [23:0] VWORD [NV] = '{24'h001234, 24'hFCABCD, 24'h015555,
    24'h020000, 24'h03FFFF, 24'h00FFFF, 24'hFFFFFF, 24'h7FFFFF, 24'h000000};
  localparam logic [15:0] VCODE [NV] = '{16'h1234, 16'hABCD, 16'hABCD,
    16'hABCD, 16'hABCD, 16'hFFFF, 16'h8000, 16'h8000, 16'h0000};
  localparam logic [1:0]  VMODE [NV] = '{2'b00, 2'b00, 2'b01,
    2'b10, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00};

  function automatic string vtag(input int i);
    case (i)
      0, 5, 8: return "R2";
      1:       return "R8";
      2, 3, 4: return "R7";
      6:       return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [3:0] term_of(input logic [1:0] m);
    case (m)
      2'b00: return 4'b0001;
      2'b01: return 4'b0010;
      2'b10: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag);
    total++;
    if (dac_code !== exp_code || op_mode !== exp_mode ||
        term_sel !== term_of(exp_mode) || pulses != exp_pulses) begin
      bad++;
      $display("FAIL %s: actual code=%h mode=%b term=%b strobes=%0d expected code=%h mode=%b term=%b strobes=%0d",
               tag, dac_code, op_mode, term_sel, pulses,
               exp_code, exp_mode, term_of(exp_mode), exp_pulses);
    end
  endtask

  task automatic sel_low();
    sel_n = 1'b0; wait_cyc(HALF);
  endtask

  task automatic sel_high();
    wait_cyc(HALF); sel_n = 1'b1; wait_cyc(HALF);
  endtask

  // send bits from position hi downward, n of them
  task automatic send_bits(input logic [23:0] w, input int hi, input int n);
    for (int i = 0; i < n; i++) begin
      sdin = w[hi - i];
      sclk = 1'b1; wait_cyc(HALF);
      sclk = 1'b0; wait_cyc(HALF);
      sclk = 1'b1;
    end
  endtask

  task automatic frame(input logic [23:0] w);
    sel_low(); send_bits(w, 23, 24); sel_high();
  endtask

  initial begin
    exp_code = 16'h8000; exp_mode = 2'b00; exp_pulses = 0;
    wait_cyc(4);
    check("R1");
    rst_n = 1'b1;
    wait_cyc(10);
    check("R1");

    // R2 R6 R7 R8 R9 R10 table
    for (int i = 0; i < NV; i++) begin
      frame(VWORD[i]);
      exp_code = VCODE[i]; exp_mode = VMODE[i]; exp_pulses++;
      check(vtag(i));
    end

    // R4 partial frame dropped
    sel_low(); send_bits(24'h00BEEF, 23, 10); sel_high();
    check("R4");

    // R3 nothing before 24th edge, then commit
    sel_low(); send_bits(24'h004321, 23, 23);
    wait_cyc(HALF);
    check("R3");
    send_bits(24'h004321, 0, 1);
    wait_cyc(HALF);
    exp_code = 16'h4321; exp_pulses++;
    check("R3");
    // R5 extra edges with select still low are ignored
    send_bits(24'h02AAAA, 23, 24);
    wait_cyc(HALF);
    check("R5");
    sel_high();
    check("R5");

    // R7 power-down then back to drive with new code
    frame(24'h010000);
    exp_mode = 2'b01; exp_pulses++;
    check("R7");
    frame(24'h00A5A5);
    exp_code = 16'hA5A5; exp_mode = 2'b00; exp_pulses++;
    check("R6");

    // R1 reset mid-operation returns power-on state
    rst_n = 1'b0; wait_cyc(3);
    exp_code = 16'h8000; exp_mode = 2'b00;
    rst_n = 1'b1; wait_cyc(6);
    check("R1");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule